// File: doc/BRIEF.md
# Floating-Point Exception Trap Controller

This block sits behind the arithmetic stage of a 64-bit floating-point pipeline. It takes in the exception flags of each retiring instruction and folds them into a sticky status register. It then decides, under one of two trap policies chosen per instruction, whether the instruction must trap. When it traps, the block produces a summary word that names the raised conditions and a one-hot mask that marks the destination register.

An operand screen runs beside the flag path and looks at the raw source operands. The arithmetic variant rejects denormals, infinities and NaNs. The compare variant lets infinities through but still rejects denormals and NaNs. The software-completion variant rejects only denormals, and only while input flushing is off. A screen trap takes the place of the flag-based decision for that instruction.

Every instruction sets up its trap report in one clock. The report shows on the outputs for exactly one cycle after the instruction is presented. Software can overwrite the sticky register at any time.

Top module: `fpx_trap_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sticky_o` is zero, `trap_valid_o` is low, and `trap_summary_o` and `trap_regmask_o` are zero.
- R2: Flag bit positions are shared by `exc_vec_i`, both masks, `sticky_o` and `trap_summary_o[5:0]`: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact, bit 5 integer overflow. Without software completion, the whole flag vector is ORed into the sticky register. A trap follows only if some bit is left after the ignore mask is cleared out, and the summary then carries exactly those remaining bits with bit 6 at zero.
- R3: With `sw_complete_i` high, ignored bits are removed before anything is logged. The remaining bits are ORed into the sticky register. If any bit remains, a trap follows whose summary is (remaining AND enable) with bit 6, the software-completion flag, set. This happens even when the AND is zero.
- R4: Without software completion, the enable mask has no effect on the trap decision or on the summary.
- R5: For a trap raised by the flag path, `trap_regmask_o` is 1 shifted left by `dest_reg_i`.
- R6: `trap_valid_o` is a single-cycle pulse in the cycle after the instruction is presented. While it is low, the summary and the mask are zero.
- R7: Screen mode 1 (arithmetic) applies to either operand. A zero exponent field (bits 62:52) with a nonzero fraction (bits 51:0) traps with summary 0x01 and leaves the sticky register unchanged. An exponent of 0x7FF traps with summary 0x01 and also sets sticky invalid.
- R8: Screen mode 2 (compare) applies to either operand. An exponent of 0x7FF traps and sets sticky invalid only if the fraction is nonzero, so infinities pass. A denormal traps with summary 0x01 and does not touch the sticky register.
- R9: Screen mode 3 (software completion) applies to either operand. A zero exponent with a nonzero fraction, whatever the sign, traps with summary 0x41 unless `flush_denorm_i` is high. Signed zero and all other values pass. Mode 0 screens nothing.
- R10: A screen trap overrides the flag vector of the same instruction. The flags are neither logged nor reported, and `trap_regmask_o` is zero.
- R11: With `sticky_wr_i` high, the sticky register takes `sticky_wdata_i`, and the same instruction's logged bits are ORed on top. With no write, the register only gains bits.
- R12: With `insn_valid_i` low, the flag inputs, the operands and the masks have no effect: no trap follows and the sticky register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| insn_valid_i | input | 1 | An instruction's flags and operands are present this cycle |
| exc_vec_i | input | 6 | Exception flags from the arithmetic unit |
| ignore_mask_i | input | 6 | Flags this instruction ignores |
| enable_mask_i | input | 6 | Trap enables used by software completion |
| sw_complete_i | input | 1 | Selects the software-completion trap policy |
| dest_reg_i | input | 5 | Destination register number |
| screen_mode_i | input | 2 | Operand screen: 0 off, 1 arithmetic, 2 compare, 3 software completion |
| flush_denorm_i | input | 1 | Inputs flushed to zero; suppresses the mode 3 denormal trap |
| src_a_i | input | 64 | Raw first source operand |
| src_b_i | input | 64 | Raw second source operand |
| sticky_wr_i | input | 1 | Overwrite the sticky register |
| sticky_wdata_i | input | 6 | Value to write into the sticky register |
| sticky_o | output | 6 | Sticky exception status |
| trap_valid_o | output | 1 | Trap report valid pulse |
| trap_summary_o | output | 7 | Raised flags in bits 5:0, software-completion flag in bit 6 |
| trap_regmask_o | output | 32 | One-hot destination register mask |

## Verification
The sticky register is the only state that lasts past one instruction. If it picks up a bit it should not hold, or loses one it should keep, the error shows on `sticky_o` one cycle after the instruction that caused it. It then stays visible until software writes the register again, so each-cycle comparison against a behavioural model catches it right away. A wrong trap decision, or a wrong summary or mask value, lasts only for the one-cycle report and shows up in the pulse cycle. For that reason the stimulus alternates screen modes, both policies and ignore/enable masks that overlap and that are disjoint. Sticky writes are placed between scenarios, so that a bit logged in error cannot hide behind one logged earlier.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int EXC_W    = 6;
    localparam int SUM_W    = EXC_W + 1;
    localparam int BIT_INV  = 0;
    localparam int BIT_DZE  = 1;
    localparam int BIT_OVF  = 2;
    localparam int BIT_UNF  = 3;
    localparam int BIT_INE  = 4;
    localparam int BIT_IOV  = 5;
    localparam int BIT_SWC  = EXC_W;

    typedef enum logic [1:0] {
        SCR_OFF   = 2'd0,
        SCR_ARITH = 2'd1,
        SCR_CMP   = 2'd2,
        SCR_SOFT  = 2'd3
    } scr_mode_e;
endpackage

// File: rtl/fpx_operand_screen.sv
module fpx_operand_screen #(
    parameter int DATA_W = 64,
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [DATA_W-2:0]      mag_i,
    input  fpx_pkg::scr_mode_e     mode_i,
    input  logic                   flush_i,
    output logic                   trap_o,
    output logic                   log_inv_o
);
    logic [EXP_W-1:0] exp_f;
    logic             exp_zero;
    logic             exp_ones;
    logic             frac_nz;

    always_comb begin
        exp_f    = mag_i[FRAC_W +: EXP_W];
        exp_zero = (exp_f == '0);
        exp_ones = (exp_f == '1);
        frac_nz  = (mag_i[FRAC_W-1:0] != '0);
        trap_o    = 1'b0;
        log_inv_o = 1'b0;
        unique case (mode_i)
            fpx_pkg::SCR_ARITH: begin
                trap_o    = (exp_zero && frac_nz) || exp_ones;
                log_inv_o = exp_ones;
            end
            fpx_pkg::SCR_CMP: begin
                trap_o    = (exp_zero || exp_ones) && frac_nz;
                log_inv_o = exp_ones && frac_nz;
            end
            fpx_pkg::SCR_SOFT: begin
                trap_o    = exp_zero && frac_nz && !flush_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fpx_exc_policy.sv
module fpx_exc_policy
    import fpx_pkg::*;
(
    input  logic [EXC_W-1:0] exc_i,
    input  logic [EXC_W-1:0] ignore_i,
    input  logic [EXC_W-1:0] enable_i,
    input  logic             soft_i,
    output logic [EXC_W-1:0] log_o,
    output logic             trap_o,
    output logic [SUM_W-1:0] summary_o
);
    logic [EXC_W-1:0] kept;

    always_comb begin
        kept   = exc_i & ~ignore_i;
        trap_o = (kept != '0);
        if (soft_i) begin
            log_o     = kept;
            summary_o = {1'b1, kept & enable_i};
        end else begin
            log_o     = exc_i;
            summary_o = {1'b0, kept};
        end
    end
endmodule

// File: rtl/fpx_trap_ctrl.sv
module fpx_trap_ctrl
    import fpx_pkg::*;
#(
    parameter int  NUM_REGS = 32,
    parameter int  DATA_W   = 64,
    parameter int  EXP_W    = 11,
    parameter int  FRAC_W   = 52,
    localparam int REG_W    = $clog2(NUM_REGS)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                insn_valid_i,
    input  logic [EXC_W-1:0]    exc_vec_i,
    input  logic [EXC_W-1:0]    ignore_mask_i,
    input  logic [EXC_W-1:0]    enable_mask_i,
    input  logic                sw_complete_i,
    input  logic [REG_W-1:0]    dest_reg_i,
    input  logic [1:0]          screen_mode_i,
    input  logic                flush_denorm_i,
    input  logic [DATA_W-1:0]   src_a_i,
    input  logic [DATA_W-1:0]   src_b_i,
    input  logic                sticky_wr_i,
    input  logic [EXC_W-1:0]    sticky_wdata_i,
    output logic [EXC_W-1:0]    sticky_o,
    output logic                trap_valid_o,
    output logic [SUM_W-1:0]    trap_summary_o,
    output logic [NUM_REGS-1:0] trap_regmask_o
);
    localparam int NUM_SRC = 2;

    typedef struct packed {
        logic [EXC_W-1:0]    sticky;
        logic                trap_v;
        logic [SUM_W-1:0]    summary;
        logic [NUM_REGS-1:0] regmask;
    } state_t;

    state_t state_d, state_q;

    scr_mode_e                    mode;
    logic [NUM_SRC-1:0][DATA_W-1:0] srcs;
    logic [NUM_SRC-1:0]           scr_trap;
    logic [NUM_SRC-1:0]           scr_log;

    assign mode    = scr_mode_e'(screen_mode_i);
    assign srcs[0] = src_a_i;
    assign srcs[1] = src_b_i;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_screen
        fpx_operand_screen #(
            .DATA_W (DATA_W),
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) screen_i (
            .mag_i     (srcs[s][DATA_W-2:0]),
            .mode_i    (mode),
            .flush_i   (flush_denorm_i),
            .trap_o    (scr_trap[s]),
            .log_inv_o (scr_log[s])
        );
    end

    logic [EXC_W-1:0] pol_log;
    logic             pol_trap;
    logic [SUM_W-1:0] pol_summary;

    fpx_exc_policy policy_i (
        .exc_i     (exc_vec_i),
        .ignore_i  (ignore_mask_i),
        .enable_i  (enable_mask_i),
        .soft_i    (sw_complete_i),
        .log_o     (pol_log),
        .trap_o    (pol_trap),
        .summary_o (pol_summary)
    );

    logic [EXC_W-1:0] base;
    logic [EXC_W-1:0] add;

    always_comb begin
        base = sticky_wr_i ? sticky_wdata_i : state_q.sticky;
        add  = '0;
        state_d.trap_v  = 1'b0;
        state_d.summary = '0;
        state_d.regmask = '0;
        if (insn_valid_i) begin
            if (|scr_trap) begin
                state_d.trap_v            = 1'b1;
                state_d.summary[BIT_INV]  = 1'b1;
                state_d.summary[BIT_SWC]  = (mode == SCR_SOFT);
                add[BIT_INV]              = |scr_log;
            end else begin
                add = pol_log;
                if (pol_trap) begin
                    state_d.trap_v  = 1'b1;
                    state_d.summary = pol_summary;
                    state_d.regmask = NUM_REGS'(1) << dest_reg_i;
                end
            end
        end
        state_d.sticky = base | add;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sticky_o       = state_q.sticky;
    assign trap_valid_o   = state_q.trap_v;
    assign trap_summary_o = state_q.summary;
    assign trap_regmask_o = state_q.regmask;
endmodule

// File: rtl/fpx_trap_ctrl_chk.sv
module fpx_trap_ctrl_chk #(
    parameter int  NUM_REGS = 32,
    localparam int REG_W    = $clog2(NUM_REGS)
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                insn_valid_i,
    input logic                sw_complete_i,
    input logic [REG_W-1:0]    dest_reg_i,
    input logic [1:0]          screen_mode_i,
    input logic                sticky_wr_i,
    input logic [5:0]          sticky_o,
    input logic                trap_valid_o,
    input logic [6:0]          trap_summary_o,
    input logic [NUM_REGS-1:0] trap_regmask_o
);
    assert_pulse_after_insn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_valid_o |-> $past(insn_valid_i));

    assert_quiet_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trap_valid_o |-> (trap_summary_o == '0 && trap_regmask_o == '0));

    assert_mask_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(trap_regmask_o));

    assert_mask_matches_dest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_regmask_o != '0) |-> (trap_regmask_o == (NUM_REGS'(1) << $past(dest_reg_i))));

    assert_screen_report_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_valid_o && trap_regmask_o == '0) |-> (trap_summary_o[5:0] == 6'h01));

    assert_swc_flag_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_summary_o[6] |-> ($past(sw_complete_i) || $past(screen_mode_i) == 2'd3));

    assert_sticky_gains_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(sticky_wr_i) |-> ((sticky_o & $past(sticky_o)) == $past(sticky_o)));

    assert_idle_holds_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(insn_valid_i) && !$past(sticky_wr_i)) |-> ($stable(sticky_o) && !trap_valid_o));
endmodule

bind fpx_trap_ctrl fpx_trap_ctrl_chk #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .insn_valid_i   (insn_valid_i),
    .sw_complete_i  (sw_complete_i),
    .dest_reg_i     (dest_reg_i),
    .screen_mode_i  (screen_mode_i),
    .sticky_wr_i    (sticky_wr_i),
    .sticky_o       (sticky_o),
    .trap_valid_o   (trap_valid_o),
    .trap_summary_o (trap_summary_o),
    .trap_regmask_o (trap_regmask_o)
);

// File: tb/fpx_trap_ctrl_tb.sv
module fpx_trap_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [5:0]  exc = '0, ign = '0, en = '0, wdata = '0;
    logic        swc = 1'b0, flush = 1'b0, wr = 1'b0;
    logic [4:0]  dest = '0;
    logic [1:0]  smode = '0;
    logic [63:0] opa = '0, opb = '0;
    logic [5:0]  sticky;
    logic        tv;
    logic [6:0]  tsum;
    logic [31:0] tmask;

    always #4 clk = ~clk;

    fpx_trap_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .insn_valid_i(insn_valid), .exc_vec_i(exc),
        .ignore_mask_i(ign), .enable_mask_i(en), .sw_complete_i(swc), .dest_reg_i(dest),
        .screen_mode_i(smode), .flush_denorm_i(flush), .src_a_i(opa), .src_b_i(opb),
        .sticky_wr_i(wr), .sticky_wdata_i(wdata), .sticky_o(sticky), .trap_valid_o(tv),
        .trap_summary_o(tsum), .trap_regmask_o(tmask)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R1";
    bit    done     = 1'b0;

    // Behavioural reference state
    logic [5:0]  m_sticky = '0;
    logic        m_tv = 1'b0;
    logic [6:0]  m_sum = '0;
    logic [31:0] m_mask = '0;

    function automatic logic [1:0] screen_ref(input logic [63:0] v, input logic [1:0] md, input logic fl);
        int  e = int'(v[62:52]);
        bit  nzf = (v[51:0] != 0);
        bit  den = (e == 0) && nzf;
        if (md == 2'd1) return {den || e == 2047, e == 2047};
        if (md == 2'd2) return {den || (e == 2047 && nzf), e == 2047 && nzf};
        if (md == 2'd3) return {den && !fl, 1'b0};
        return 2'b00;
    endfunction

    always @(posedge clk) begin
        logic [1:0] sa, sb;
        logic [5:0] add, kept;
        if (!rst_n) begin
            m_sticky = '0; m_tv = 0; m_sum = '0; m_mask = '0;
        end else begin
            add = '0; m_tv = 0; m_sum = '0; m_mask = '0;
            if (insn_valid) begin
                sa = screen_ref(opa, smode, flush);
                sb = screen_ref(opb, smode, flush);
                if (sa[1] || sb[1]) begin
                    m_tv = 1;
                    m_sum = (smode == 2'd3) ? 7'h41 : 7'h01;
                    if (sa[0] || sb[0]) add = 6'h01;
                end else begin
                    for (int i = 0; i < 6; i++) kept[i] = exc[i] && !ign[i];
                    add = swc ? kept : exc;
                    if (kept != 0) begin
                        m_tv = 1;
                        m_sum = swc ? {1'b1, kept & en} : {1'b0, kept};
                        m_mask = 32'd1 << dest;
                    end
                end
            end
            m_sticky = (wr ? wdata : m_sticky) | add;
        end
    end

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(tag, "sticky", 64'(sticky), 64'(m_sticky));
            check(tag, "trap_valid", 64'(tv), 64'(m_tv));
            check(tag, "summary", 64'(tsum), 64'(m_sum));
            check(tag, "regmask", 64'(tmask), 64'(m_mask));
        end
    end

    task automatic idle();
        insn_valid = 0; wr = 0;
    endtask

    task automatic issue(input string t, input logic [5:0] e, input logic [5:0] ig, input logic [5:0] enb,
                         input logic s, input logic [4:0] d, input logic [1:0] md, input logic fl,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        tag = t; insn_valid = 1; wr = 0; exc = e; ign = ig; en = enb; swc = s; dest = d;
        smode = md; flush = fl; opa = a; opb = b;
        @(negedge clk);
        idle();
    endtask

    task automatic clear_sticky(input string t);
        @(negedge clk);
        tag = t; insn_valid = 0; wr = 1; wdata = '0;
        @(negedge clk);
        idle();
    endtask

    localparam logic [63:0] ONE  = 64'h3FF0000000000000;
    localparam logic [63:0] DEN  = 64'h0000000000000001;
    localparam logic [63:0] NDEN = 64'h8000000000000010;
    localparam logic [63:0] NZRO = 64'h8000000000000000;
    localparam logic [63:0] INF  = 64'h7FF0000000000000;
    localparam logic [63:0] NAN  = 64'hFFF8000000000000;

    function automatic logic [63:0] pick_op(input int k);
        case (k)
            0: return DEN;  1: return NDEN; 2: return NZRO;
            3: return INF;  4: return NAN;  default: return ONE;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "sticky in reset", 64'(sticky), 0);
        check("R1", "trap in reset", 64'(tv), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1", "sticky after reset", 64'(sticky), 0);
        check("R1", "regmask after reset", 64'(tmask), 0);

        // R2: non-completing policy
        issue("R2", 6'b010001, 6'h00, 6'h00, 0, 5'd3, 2'd0, 0, ONE, ONE);
        check("R2", "summary literal", 64'(tsum), 64'h11);
        check("R5", "mask literal", 64'(tmask), 64'h8);
        clear_sticky("R11");
        issue("R2", 6'b010000, 6'b010000, 6'h00, 0, 5'd1, 2'd0, 0, ONE, ONE);
        check("R2", "ignored bit no trap", 64'(tv), 0);
        check("R2", "ignored bit still logged", 64'(sticky), 64'h10);
        // R4: enable mask has no effect without completion
        issue("R4", 6'b100100, 6'h00, 6'h00, 0, 5'd31, 2'd0, 0, ONE, ONE);
        check("R4", "enable ignored", 64'(tsum), 64'h24);
        check("R5", "mask reg 31", 64'(tmask), 64'h80000000);
        clear_sticky("R11");
        // R3: software completion
        issue("R3", 6'b000110, 6'b000010, 6'h00, 1, 5'd0, 2'd0, 0, ONE, ONE);
        check("R3", "swc no enables", 64'(tsum), 64'h40);
        check("R3", "ignored bit not logged", 64'(sticky), 64'h04);
        issue("R3", 6'b000110, 6'b000010, 6'b000100, 1, 5'd7, 2'd0, 0, ONE, ONE);
        check("R3", "swc enabled", 64'(tsum), 64'h44);
        clear_sticky("R11");
        issue("R3", 6'b001000, 6'b001000, 6'h3F, 1, 5'd7, 2'd0, 0, ONE, ONE);
        check("R3", "all ignored no trap", 64'(tv), 0);
        check("R3", "all ignored not logged", 64'(sticky), 0);
        // R7: arithmetic screen
        issue("R7", 6'h00, 6'h00, 6'h00, 0, 5'd2, 2'd1, 0, DEN, ONE);
        check("R7", "denormal traps", 64'(tsum), 64'h01);
        check("R7", "denormal no sticky", 64'(sticky), 0);
        issue("R7", 6'h00, 6'h00, 6'h00, 0, 5'd2, 2'd1, 0, ONE, INF);
        check("R7", "inf sets sticky", 64'(sticky), 64'h01);
        clear_sticky("R11");
        // R8: compare screen
        issue("R8", 6'h00, 6'h00, 6'h00, 0, 5'd2, 2'd2, 0, INF, ONE);
        check("R8", "inf passes", 64'(tv), 0);
        issue("R8", 6'h00, 6'h00, 6'h00, 0, 5'd2, 2'd2, 0, ONE, NAN);
        check("R8", "nan traps", 64'(tsum), 64'h01);
        check("R8", "nan sticky", 64'(sticky), 64'h01);
        clear_sticky("R11");
        issue("R8", 6'h00, 6'h00, 6'h00, 0, 5'd2, 2'd2, 0, NDEN, ONE);
        check("R8", "cmp denormal no sticky", 64'(sticky), 0);
        // R9: completing screen
        issue("R9", 6'h00, 6'h00, 6'h00, 1, 5'd4, 2'd3, 0, NDEN, ONE);
        check("R9", "neg denormal traps", 64'(tsum), 64'h41);
        issue("R9", 6'h00, 6'h00, 6'h00, 1, 5'd4, 2'd3, 1, NDEN, DEN);
        check("R9", "flush suppresses", 64'(tv), 0);
        issue("R9", 6'h00, 6'h00, 6'h00, 1, 5'd4, 2'd3, 0, NZRO, INF);
        check("R9", "neg zero and inf pass", 64'(tv), 0);
        // R10: screen overrides flags
        issue("R10", 6'b110110, 6'h00, 6'h3F, 0, 5'd9, 2'd1, 0, DEN, ONE);
        check("R10", "flags dropped", 64'(tsum), 64'h01);
        check("R10", "no mask", 64'(tmask), 0);
        check("R10", "flags not logged", 64'(sticky), 0);
        // R11: write with simultaneous instruction
        @(negedge clk);
        tag = "R11"; insn_valid = 1; wr = 1; wdata = 6'b100000; exc = 6'b000010;
        ign = 0; swc = 0; smode = 0; dest = 5'd5;
        @(negedge clk);
        idle();
        check("R11", "write plus log", 64'(sticky), 64'h22);
        // R12: no instruction, no effect
        @(negedge clk);
        tag = "R12"; insn_valid = 0; exc = 6'h3F; smode = 2'd1; opa = INF;
        @(negedge clk);
        check("R12", "no trap when idle", 64'(tv), 0);
        check("R12", "sticky held when idle", 64'(sticky), 64'h22);

        // Mixed stimulus
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            tag = (n % 2 == 0) ? "R3" : "R2";
            insn_valid = ($urandom_range(0, 3) != 0);
            wr = ($urandom_range(0, 9) == 0);
            wdata = 6'($urandom);
            exc = 6'($urandom); ign = 6'($urandom); en = 6'($urandom);
            swc = 1'($urandom); dest = 5'($urandom); flush = 1'($urandom);
            smode = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'd0;
            opa = pick_op($urandom_range(0, 8));
            opb = pick_op($urandom_range(0, 8));
        end
        @(negedge clk);
        idle();
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R6 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule